// File: doc/BRIEF.md
# Two-Wire Slave Start Detector and Clock Stretcher

This block is the bit-level slave front end for an I2C-compatible two-wire bus. It watches the SCL and SDA bus levels, recognises start and stop conditions, shifts received bits into a byte register and counts every SCL edge in a small counter. When a start is seen, or when the counter wraps, it pulls SCL low and keeps it low until firmware has handled the event. Firmware clears the flags by writing ones.

Both bus lines are modelled as open-drain. The block only produces pull-down enables, and the bus level it sees is the wired-AND of every driver. SDA passes through a short delay line before the start and stop detector. If a master lowers SCL and SDA in the same cycle, the delayed SDA change is then seen while SCL is already low, so it is not taken for a start.

Firmware handles the acknowledge slot with a preload. It writes a byte whose MSB is 0, enables the SDA driver and preloads the counter to 14. It then clears the overflow flag. After one more SCL pulse the counter wraps again and the clock is stretched once more.

Top module: `twi_start_hold`

## Requirements
- R1: After reset, all three flags are 0, the counter is 0, the shift register is 0xFF, and neither pull-down enable is active.
- R2: While two-wire mode is enabled, SDA falling while SCL is high sets the start flag. The SDA used for this test is delayed by SDA_DLY clocks.
- R3: If SCL and SDA fall in the same clock, the start flag is not set.
- R4: If the start flag is set, the first falling SCL edge turns on the SCL pull-down one clock later. The pull-down stays on until both the start flag and the overflow flag read 0.
- R5: The counter adds one on every SCL edge, rising and falling. On the edge that takes it from 15 to 0, it sets the overflow flag and turns on the SCL pull-down.
- R6: With the counter preloaded to 14, exactly one SCL pulse (rise then fall) sets the overflow flag again and stretches SCL.
- R7: SDA is sampled on each rising SCL edge. The shift register moves left on each falling edge, taking in the sampled bit. Eight pulses therefore deliver a byte MSB first.
- R8: The SDA pull-down is on exactly when the SDA output enable is 1 and bit 7 of the shift register is 0.
- R9: While enabled, SDA rising while SCL is high (delayed the same way) sets the stop flag.
- R10: A 1 on a flag's clear input clears that flag on the next clock. If a setting event arrives in the same clock, the flag is set instead.
- R11: While two-wire mode is disabled, SCL edges do not change the counter or the shift register, and no flag is set.
- R12: A firmware write to the counter or shift register takes priority over an SCL edge in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| twi_en | input | 1 | Two-wire mode enable |
| scl_in | input | 1 | SCL bus level (wired-AND) |
| sda_in | input | 1 | SDA bus level (wired-AND) |
| sda_oe | input | 1 | Allows the shift register MSB to drive SDA |
| dr_wr | input | 1 | Shift register write strobe |
| dr_wdata | input | 8 | Shift register write data |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 4 | Counter write data |
| clr_start | input | 1 | Write-one-to-clear for the start flag |
| clr_stop | input | 1 | Write-one-to-clear for the stop flag |
| clr_ovf | input | 1 | Write-one-to-clear for the overflow flag |
| scl_pd | output | 1 | SCL pull-down enable (clock hold) |
| sda_pd | output | 1 | SDA pull-down enable |
| dr_rdata | output | 8 | Shift register contents |
| cnt_val | output | 4 | Edge counter value |
| start_flag | output | 1 | Start condition seen |
| stop_flag | output | 1 | Stop condition seen |
| ovf_flag | output | 1 | Counter wrapped |

## Verification
The bench drives SCL and SDA falling in the same clock. A detector that skipped the SDA delay would raise a false start there. It counts the edges around the acknowledge preload: a counter that ignored rising edges, or wrapped one edge off, would stretch SCL in the middle of the ACK bit or after it. It holds a clear strobe high across a start event, which exposes a clear that beats the set, and it lines firmware writes up with SCL edges, which exposes a write that loses to the shift or the count. A hold that let go after clearing only one of its two flags would show up as an early drop of the SCL pull-down.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef struct packed {
    logic start;
    logic stop;
    logic ovf;
  } twi_flags_t;

  typedef struct packed {
    logic rise;
    logic fall;
    logic start;
    logic stop;
  } twi_evt_t;

endpackage

// File: rtl/twi_line_sampler.sv
module twi_line_sampler
  import twi_pkg::*;
#(
  parameter int SDA_DLY = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     scl_in,
  input  logic     sda_in,
  output twi_evt_t evt
);

  logic [SDA_DLY-1:0] sda_pipe;
  logic               sda_cur;
  logic               sda_prev;
  logic               scl_prev;

  generate
    if (SDA_DLY == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sda_pipe <= '1;
        else        sda_pipe <= sda_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sda_pipe <= '1;
        else        sda_pipe <= {sda_pipe[SDA_DLY-2:0], sda_in};
      end
    end
  endgenerate

  assign sda_cur = sda_pipe[SDA_DLY-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_prev <= 1'b1;
      scl_prev <= 1'b1;
    end else begin
      sda_prev <= sda_cur;
      scl_prev <= scl_in;
    end
  end

  always_comb begin
    evt.rise  = en &  scl_in & ~scl_prev;
    evt.fall  = en & ~scl_in &  scl_prev;
    evt.start = en &  scl_in &  sda_prev & ~sda_cur;
    evt.stop  = en &  scl_in & ~sda_prev &  sda_cur;
  end

endmodule

// File: rtl/twi_shift_count.sv
module twi_shift_count #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_in,
  input  logic              dr_wr,
  input  logic [DATA_W-1:0] dr_wdata,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  output logic [DATA_W-1:0] sr,
  output logic [CNT_W-1:0]  cnt,
  output logic              ovf_evt
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return c + CNT_ONE;
  endfunction

  function automatic logic cnt_last(input logic [CNT_W-1:0] c);
    return &c;
  endfunction

  function automatic logic [DATA_W-1:0] shl_in(input logic [DATA_W-1:0] d, input logic b);
    return {d[DATA_W-2:0], b};
  endfunction

  logic bit_q;
  logic edge_any;

  assign edge_any = scl_rise | scl_fall;
  assign ovf_evt  = edge_any & ~cnt_wr & cnt_last(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (cnt_wr)   cnt <= cnt_wdata;
    else if (edge_any) cnt <= cnt_step(cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bit_q <= 1'b1;
    else if (scl_rise) bit_q <= sda_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr <= '1;
    else if (dr_wr)    sr <= dr_wdata;
    else if (scl_fall) sr <= shl_in(sr, bit_q);
  end

  // R5
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> cnt == '0);

  // R7
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && !dr_wr) |=> sr[DATA_W-1:1] == $past(sr[DATA_W-2:0]));

  // R12
  cnt_wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(cnt_wdata));

endmodule

// File: rtl/twi_hold_ctrl.sv
module twi_hold_ctrl
  import twi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  twi_evt_t   evt,
  input  logic       ovf_evt,
  input  logic       clr_start,
  input  logic       clr_stop,
  input  logic       clr_ovf,
  output twi_flags_t flags,
  output logic       hold
);

  logic hold_set;
  logic hold_free;

  assign hold_set  = (evt.fall & flags.start) | ovf_evt;
  assign hold_free = ~flags.start & ~flags.ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags.start <= evt.start | (flags.start & ~clr_start);
      flags.stop  <= evt.stop  | (flags.stop  & ~clr_stop);
      flags.ovf   <= ovf_evt   | (flags.ovf   & ~clr_ovf);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold <= 1'b0;
    else if (hold_set)  hold <= 1'b1;
    else if (hold_free) hold <= 1'b0;
  end

  // R4
  hold_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.fall && flags.start) |=> hold);

  // R4
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> $past(!flags.start && !flags.ovf));

  // R10
  start_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.start |=> flags.start);

  // R5
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (hold && flags.ovf));

endmodule

// File: rtl/twi_start_hold.sv
module twi_start_hold
  import twi_pkg::*;
#(
  parameter int SDA_DLY = 3,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              twi_en,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              sda_oe,
  input  logic              dr_wr,
  input  logic [DATA_W-1:0] dr_wdata,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              clr_start,
  input  logic              clr_stop,
  input  logic              clr_ovf,
  output logic              scl_pd,
  output logic              sda_pd,
  output logic [DATA_W-1:0] dr_rdata,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              start_flag,
  output logic              stop_flag,
  output logic              ovf_flag
);

  twi_evt_t   evt;
  twi_flags_t flags;
  logic       ovf_evt;
  logic       hold;

  twi_line_sampler #(.SDA_DLY(SDA_DLY)) u_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (twi_en),
    .scl_in (scl_in),
    .sda_in (sda_in),
    .evt    (evt)
  );

  twi_shift_count #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_sc (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (evt.rise),
    .scl_fall  (evt.fall),
    .sda_in    (sda_in),
    .dr_wr     (dr_wr),
    .dr_wdata  (dr_wdata),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .sr        (dr_rdata),
    .cnt       (cnt_val),
    .ovf_evt   (ovf_evt)
  );

  twi_hold_ctrl u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .ovf_evt   (ovf_evt),
    .clr_start (clr_start),
    .clr_stop  (clr_stop),
    .clr_ovf   (clr_ovf),
    .flags     (flags),
    .hold      (hold)
  );

  assign scl_pd     = hold;
  assign sda_pd     = sda_oe & ~dr_rdata[DATA_W-1];
  assign start_flag = flags.start;
  assign stop_flag  = flags.stop;
  assign ovf_flag   = flags.ovf;

  // R8
  sda_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sda_oe |-> !sda_pd);

  // R11
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!twi_en && !cnt_wr) |=> $stable(cnt_val));

endmodule

// File: tb/tb_twi_start_hold.sv
`timescale 1ns/100ps
module tb_twi_start_hold;

  localparam int D = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       twi_en = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic       sda_oe = 1'b0, dr_wr = 1'b0, cnt_wr = 1'b0;
  logic [7:0] dr_wdata = 8'h00;
  logic [3:0] cnt_wdata = 4'h0;
  logic       clr_start = 1'b0, clr_stop = 1'b0, clr_ovf = 1'b0;
  logic       scl_pd, sda_pd, start_flag, stop_flag, ovf_flag;
  logic [7:0] dr_rdata;
  logic [3:0] cnt_val;
  wire        scl_bus = m_scl & ~scl_pd;
  wire        sda_bus = m_sda & ~sda_pd;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  twi_start_hold #(.SDA_DLY(D)) dut (
    .clk(clk), .rst_n(rst_n), .twi_en(twi_en), .scl_in(scl_bus), .sda_in(sda_bus),
    .sda_oe(sda_oe), .dr_wr(dr_wr), .dr_wdata(dr_wdata), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .clr_start(clr_start), .clr_stop(clr_stop),
    .clr_ovf(clr_ovf), .scl_pd(scl_pd), .sda_pd(sda_pd), .dr_rdata(dr_rdata),
    .cnt_val(cnt_val), .start_flag(start_flag), .stop_flag(stop_flag),
    .ovf_flag(ovf_flag)
  );

  // behavioural reference model
  int q[$];
  int mp, mps, mb, msr, mc, ms, mt, mo, mh;

  task automatic model_init();
    q = {};
    for (int i = 0; i < D; i++) q.push_back(1);
    mp = 1; mps = 1; mb = 1; msr = 255; mc = 0; ms = 0; mt = 0; mo = 0; mh = 0;
  endtask

  initial model_init();

  always @(posedge clk) begin
    if (!rst_n) model_init();
    else begin
      int sclb, sdab, cur, st, sp, rs, fl, ov, en;
      en   = twi_en ? 1 : 0;
      sclb = (m_scl && mh == 0) ? 1 : 0;
      sdab = (m_sda && !(sda_oe && msr < 128)) ? 1 : 0;
      cur  = q[D-1];
      st = (en && sclb && mp == 1 && cur == 0) ? 1 : 0;
      sp = (en && sclb && mp == 0 && cur == 1) ? 1 : 0;
      rs = (en && sclb && mps == 0) ? 1 : 0;
      fl = (en && !sclb && mps == 1) ? 1 : 0;
      ov = 0;
      if (cnt_wr) mc = cnt_wdata;
      else if (rs || fl) begin
        ov = (mc == 15) ? 1 : 0;
        mc = (mc + 1) % 16;
      end
      if ((fl && ms) || ov) mh = 1;
      else if (!ms && !mo) mh = 0;
      ms = st ? 1 : (clr_start ? 0 : ms);
      mt = sp ? 1 : (clr_stop ? 0 : mt);
      mo = ov ? 1 : (clr_ovf ? 0 : mo);
      if (dr_wr) msr = dr_wdata;
      else if (fl) msr = ((msr << 1) | mb) & 255;
      if (rs) mb = sdab;
      void'(q.pop_back());
      q.push_front(sdab);
      mp = cur;
      mps = sclb;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int pd;
      pd = (sda_oe && msr < 128) ? 1 : 0;
      chk(scl_pd == mh[0], "R4 scl_pd", scl_pd, mh);
      chk(sda_pd == pd[0], "R8 sda_pd", sda_pd, pd);
      chk(dr_rdata == msr[7:0], "R7 dr_rdata", dr_rdata, msr);
      chk(cnt_val == mc[3:0], "R5 cnt_val", cnt_val, mc);
      chk(start_flag == ms[0], "R2 start_flag", start_flag, ms);
      chk(stop_flag == mt[0], "R9 stop_flag", stop_flag, mt);
      chk(ovf_flag == mo[0], "R5 ovf_flag", ovf_flag, mo);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_bit(input logic b);
    m_sda = b;     step(D + 2);
    m_scl = 1'b1;  step(D + 2);
    m_scl = 1'b0;  step(D + 2);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    logic [7:0] byte_v;
    logic [3:0] cnt_keep;
    byte_v = 8'hA5;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk(start_flag == 0 && stop_flag == 0 && ovf_flag == 0, "R1 flags", {start_flag, stop_flag, ovf_flag}, 0);
    chk(cnt_val == 0 && dr_rdata == 8'hFF, "R1 cnt/dr", {cnt_val, dr_rdata}, 12'h0FF);
    chk(scl_pd == 0 && sda_pd == 0, "R1 pulldowns", {scl_pd, sda_pd}, 0);

    twi_en = 1'b1;
    step(5);
    // R2 start condition
    m_sda = 1'b0; step(D + 3);
    chk(start_flag == 1, "R2 start set", start_flag, 1);
    // R4 hold after falling SCL
    m_scl = 1'b0; step(3);
    chk(scl_pd == 1, "R4 hold on", scl_pd, 1);
    step(4);
    chk(scl_pd == 1, "R4 hold kept", scl_pd, 1);
    cnt_wr = 1'b1; cnt_wdata = 4'd0; clr_start = 1'b1; step(1);
    cnt_wr = 1'b0; clr_start = 1'b0; step(2);
    chk(scl_pd == 0, "R4 hold released", scl_pd, 0);
    chk(start_flag == 0, "R10 start cleared", start_flag, 0);

    // R7 receive a byte MSB first
    for (int i = 7; i >= 0; i--) pulse_bit(byte_v[i]);
    chk(dr_rdata == 8'hA5, "R7 byte", dr_rdata, 8'hA5);
    chk(ovf_flag == 1 && scl_pd == 1, "R5 overflow hold", {ovf_flag, scl_pd}, 2'b11);
    chk(cnt_val == 0, "R5 wrapped", cnt_val, 0);

    // R6 acknowledge with preload 14
    dr_wr = 1'b1; dr_wdata = 8'h7F; sda_oe = 1'b1;
    cnt_wr = 1'b1; cnt_wdata = 4'd14; clr_ovf = 1'b1; step(1);
    dr_wr = 1'b0; cnt_wr = 1'b0; clr_ovf = 1'b0; step(2);
    chk(sda_pd == 1, "R8 ack drive", sda_pd, 1);
    chk(scl_pd == 0, "R6 released for ack", scl_pd, 0);
    pulse_bit(1'b1);
    chk(ovf_flag == 1 && scl_pd == 1, "R6 hold after ack", {ovf_flag, scl_pd}, 2'b11);
    chk(sda_pd == 0, "R8 released after shift", sda_pd, 0);
    sda_oe = 1'b0; clr_ovf = 1'b1; step(1);
    clr_ovf = 1'b0; step(2);
    chk(scl_pd == 0, "R4 release after ovf clear", scl_pd, 0);

    // R9 stop condition
    m_sda = 1'b0; step(D + 2);
    m_scl = 1'b1; step(D + 2);
    m_sda = 1'b1; step(D + 3);
    chk(stop_flag == 1, "R9 stop set", stop_flag, 1);
    clr_stop = 1'b1; step(1);
    clr_stop = 1'b0;
    chk(stop_flag == 0, "R10 stop cleared", stop_flag, 0);

    // R10 clear held across a start event: set wins for one clock
    clr_start = 1'b1;
    m_sda = 1'b0; step(D + 4);
    clr_start = 1'b0; step(1);
    chk(start_flag == 0, "R10 start after held clear", start_flag, 0);
    m_sda = 1'b1; step(D + 3);
    clr_stop = 1'b1; step(1);
    clr_stop = 1'b0; step(2);

    // R3 simultaneous fall is not a start
    m_scl = 1'b0; m_sda = 1'b0; step(D + 3);
    chk(start_flag == 0, "R3 no false start", start_flag, 0);
    chk(scl_pd == 0, "R3 no hold", scl_pd, 0);
    m_sda = 1'b1; step(D + 2);
    m_scl = 1'b1; step(D + 2);

    // R11 disabled mode
    twi_en = 1'b0; step(1);
    cnt_keep = cnt_val;
    m_sda = 1'b0; step(D + 3);
    chk(start_flag == 0, "R11 no start when off", start_flag, 0);
    m_scl = 1'b0; step(D + 2);
    pulse_bit(1'b1);
    pulse_bit(1'b0);
    chk(cnt_val == cnt_keep, "R11 counter frozen", cnt_val, cnt_keep);
    m_sda = 1'b1; step(D + 3);
    chk(stop_flag == 0, "R11 no stop when off", stop_flag, 0);
    twi_en = 1'b1; step(D + 2);

    // R12 writes beat edges
    m_scl = 1'b1; cnt_wr = 1'b1; cnt_wdata = 4'd3; step(1);
    cnt_wr = 1'b0;
    chk(cnt_val == 3, "R12 cnt write wins", cnt_val, 3);
    step(D + 2);
    m_scl = 1'b0; dr_wr = 1'b1; dr_wdata = 8'h3C; step(1);
    dr_wr = 1'b0;
    chk(dr_rdata == 8'h3C, "R12 dr write wins", dr_rdata, 8'h3C);
    step(D + 2);
    pulse_bit(1'b1);
    chk(dr_rdata == 8'h79, "R7 shift after write", dr_rdata, 8'h79);
    step(4);
    finish_run();
  end

endmodule